// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This block is a memory-mapped real-time seconds counter split across two clocks. A 32-bit register port runs on the fast bus clock. The counting logic runs on a slow, unrelated low-power clock. Every bus write is captured once in a holding register and handed to the slow domain through a toggle request/acknowledge handshake. While that handshake is in flight, a write-pending bit is readable and further writes are dropped.

After reset the counter is locked in an initial state. Software first loads a fixed key into the glitch-detector register and requests init exit. It then requests exit from the non-valid state, which leaves the block running. Once running and enabled, a prescaler advances on each slow clock edge, and every prescaler wrap adds one to the seconds word. When the seconds word becomes equal to the alarm register, an alarm flag is set. That flag drives an interrupt output and a wake output through separate enable bits.

Top module: `lp_seconds_rtc`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `wake` are low.
- R2: The init-exit request (control bit 15) is honoured only while the glitch register (offset 0x18) holds 0x41736166. Any other value keeps status bit 15 at 0.
- R3: The non-valid-exit request (control bit 14) has effect only after init exit has completed. Status bit 14 reports the running state.
- R4: Writes to the seconds word (0x00) and the alarm (0x08) are ignored until status bit 14 is set.
- R5: While running with control bit 3 set, the seconds word advances once per 2^PRE_W slow clock cycles.
- R6: The prescaler, readable at offset 0x04 in bits PRE_W-1:0, changes on every slow clock edge while counting.
- R7: The seconds word is a full 32-bit unsigned value that accepts any written value and wraps from 0xFFFFFFFF to 0.
- R8: Status bit 3 is set when the seconds word becomes equal to the alarm register.
- R9: Status bit 3 stays set until a status write (0x14) with bit 3 at one. Writing zero there leaves it set.
- R10: `irq` equals status bit 3 AND control bit 7, and `wake` equals status bit 3 AND control bit 4.
- R11: Status bit 0 is set from the cycle after an accepted write until the write has been applied in the slow domain. A write issued while it is set is dropped.
- R12: With control bit 3 clear, the seconds word holds its value even in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lp_clk | input | 1 | Slow low-power counting clock |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wake-up request |

## Verification
A lifecycle state that is wrong shows in status bits 15 and 14 within a few slow clock cycles of the request being applied. It also shows as counter or alarm writes that take effect, or do not, when they should not. A prescaler or carry fault shows as a wrong seconds difference after a known number of slow cycles. A match fault shows as an alarm flag that is missing or misplaced, together with `irq`/`wake`, within one second of the expected match. A handshake fault shows at once in the pending bit, or as a dropped write that still lands.

// File: rtl/lp_seconds_rtc.sv
module lp_seconds_rtc #(
  parameter int          PRE_W      = 15,
  parameter logic [31:0] GLITCH_KEY = 32'h41736166
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lp_clk,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wake
);
  localparam logic [4:0] A_SEC = 5'h00, A_PRE = 5'h04, A_ALM = 5'h08;
  localparam logic [4:0] A_CTL = 5'h10, A_STS = 5'h14, A_GLT = 5'h18;
  localparam int B_EN = 3, B_WAKE = 4, B_IE = 7, B_NV = 14, B_INIT = 15;
  localparam int B_ALF = 3;

  typedef enum logic [1:0] {ST_INIT = 2'd0, ST_NVAL = 2'd1, ST_RUN = 2'd2} life_t;

  logic        req_t, ack_t, ack_s1, ack_s2, pending;
  logic [4:0]  h_addr;
  logic [31:0] h_data;

  assign pending = req_t ^ ack_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      h_addr <= '0;
      h_data <= '0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (bus_sel && bus_we && !pending) begin
        h_addr <= bus_addr;
        h_data <= bus_wdata;
        req_t  <= ~req_t;
      end
    end
  end

  logic             req_s1, req_s2, req_s3, apply;
  life_t            life;
  logic [31:0]      seconds, alarm, glitch;
  logic [PRE_W-1:0] pre;
  logic [15:0]      ctrl;
  logic             flag, match_q, match, tick, running;

  assign apply   = req_s2 ^ req_s3;
  assign running = (life == ST_RUN);
  assign tick    = running && ctrl[B_EN];
  assign match   = (seconds == alarm);

  always_ff @(posedge lp_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1  <= 1'b0;
      req_s2  <= 1'b0;
      req_s3  <= 1'b0;
      ack_t   <= 1'b0;
      life    <= ST_INIT;
      seconds <= '0;
      alarm   <= '0;
      glitch  <= '0;
      pre     <= '0;
      ctrl    <= '0;
      flag    <= 1'b0;
      match_q <= 1'b1;
    end else begin
      req_s1  <= req_t;
      req_s2  <= req_s1;
      req_s3  <= req_s2;
      match_q <= match;
      if (apply) ack_t <= req_s2;
      if (apply && h_addr == A_CTL) ctrl <= h_data[15:0];
      if (apply && h_addr == A_GLT) glitch <= h_data;
      if (apply && h_addr == A_ALM && running) alarm <= h_data;

      if (apply && h_addr == A_SEC && running) begin
        seconds <= h_data;
        pre     <= '0;
      end else if (tick) begin
        pre <= pre + 1'b1;
        if (&pre) seconds <= seconds + 32'd1;
      end

      case (life)
        ST_INIT: if (ctrl[B_INIT] && glitch == GLITCH_KEY) life <= ST_NVAL;
        ST_NVAL: if (ctrl[B_NV]) life <= ST_RUN;
        default: life <= ST_RUN;
      endcase

      if (running && match && !match_q) flag <= 1'b1;
      else if (apply && h_addr == A_STS && h_data[B_ALF]) flag <= 1'b0;
    end
  end

  assign irq  = flag & ctrl[B_IE];
  assign wake = flag & ctrl[B_WAKE];

  always_comb begin
    case (bus_addr)
      A_SEC:   bus_rdata = seconds;
      A_PRE:   bus_rdata = {{(32-PRE_W){1'b0}}, pre};
      A_ALM:   bus_rdata = alarm;
      A_CTL:   bus_rdata = {16'h0, ctrl};
      A_STS:   bus_rdata = {16'h0, life != ST_INIT, running, 10'h0, flag, 2'b00, pending};
      A_GLT:   bus_rdata = glitch;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lp_seconds_rtc_chk.sv
module lp_seconds_rtc_chk #(
  parameter logic [31:0] KEY = 32'h41736166
) (
  input logic        clk,
  input logic        lp_clk,
  input logic        rst_n,
  input logic [1:0]  life,
  input logic [31:0] glitch,
  input logic [31:0] seconds,
  input logic [31:0] alarm,
  input logic        flag,
  input logic        pending,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [31:0] h_data
);
  p_init_key_r2: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (life == 2'd0 && glitch != KEY) |=> life == 2'd0);

  p_order_r3: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (life == 2'd0) |=> life != 2'd2);

  p_frozen_r4: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (life != 2'd2) |=> ($stable(seconds) && $stable(alarm)));

  p_alarm_match_r8: assert property (@(posedge lp_clk) disable iff (!rst_n)
    $rose(flag) |-> seconds == alarm);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && bus_sel && bus_we) |=> $stable(h_data));
endmodule

bind lp_seconds_rtc lp_seconds_rtc_chk #(.KEY(GLITCH_KEY)) u_chk (
  .clk(clk), .lp_clk(lp_clk), .rst_n(rst_n), .life(life), .glitch(glitch),
  .seconds(seconds), .alarm(alarm), .flag(flag), .pending(pending),
  .bus_sel(bus_sel), .bus_we(bus_we), .h_data(h_data)
);

// File: tb/lp_seconds_rtc_tb.sv
module lp_seconds_rtc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LP_HALF    = 35;
  localparam int PRE_W      = 3;
  localparam int SEC_LP     = 1 << PRE_W;
  localparam logic [31:0] KEY = 32'h41736166;

  logic        clk = 0, lp_clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq, wake;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(LP_HALF) lp_clk = ~lp_clk;

  lp_seconds_rtc #(.PRE_W(PRE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr_raw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic settle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(5'h14, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_raw(a, d);
    settle();
  endtask

  task automatic wait_lp(input int n);
    repeat (n) @(posedge lp_clk);
    @(negedge clk);
  endtask

  function automatic bit near(input logic [31:0] got, input logic [31:0] base, input int lo, input int hi);
    logic [31:0] d = got - base;
    return (int'(d) >= lo) && (int'(d) <= hi);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s0, s1, p0, p1;
    void'($urandom(32'h5EC0_0D5));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(5'h00, v); chk(v == 0, "R1 seconds", v, 0);
    rd(5'h10, v); chk(v == 0, "R1 control", v, 0);
    rd(5'h14, v); chk(v == 0, "R1 status", v, 0);
    rd(5'h18, v); chk(v == 0, "R1 glitch", v, 0);
    chk(irq == 0 && wake == 0, "R1 outputs", {30'h0, irq, wake}, 0);

    wr(5'h00, 32'h55); rd(5'h00, v); chk(v == 0, "R4 seconds write in init", v, 0);
    wr(5'h08, 32'h77); rd(5'h08, v); chk(v == 0, "R4 alarm write in init", v, 0);

    wr_raw(5'h10, 32'h4808);
    rd(5'h14, v); chk(v[0] == 1, "R11 pending after write", v, 1);
    settle(); wait_lp(4);
    rd(5'h14, v); chk(v[15:14] == 0, "R3 nv exit before init", v, 0);

    wr(5'h18, 32'h12345678); wr(5'h10, 32'h8808); wait_lp(4);
    rd(5'h14, v); chk(v[15] == 0, "R2 wrong key holds init", v, 0);
    wr(5'h18, KEY); wait_lp(4);
    rd(5'h14, v); chk(v[15:14] == 2'b10, "R2 key accepted", {30'h0, v[15:14]}, 2);
    wr(5'h00, 32'h99); rd(5'h00, v); chk(v == 0, "R4 seconds write in non-valid", v, 0);
    wr(5'h10, 32'hC808); wait_lp(4);
    rd(5'h14, v); chk(v[15:14] == 2'b11, "R3 running", {30'h0, v[15:14]}, 3);

    rd(5'h00, s0); wait_lp(10 * SEC_LP); rd(5'h00, s1);
    chk(near(s1, s0, 9, 11), "R5 ten seconds", s1 - s0, 10);
    rd(5'h04, p0); wait_lp(1); rd(5'h04, p1);
    chk(p0 != p1, "R6 prescaler moves", p1, p0 + 1);

    for (int i = 0; i < 6; i++) begin
      v = $urandom;
      wr(5'h00, v); rd(5'h00, s1);
      chk(near(s1, v, 0, 1), "R7 random seconds load", s1, v);
    end
    wr(5'h00, 32'hFFFF_FFFF); wait_lp(2 * SEC_LP); rd(5'h00, s1);
    chk(s1 == 1 || s1 == 2, "R7 wrap through zero", s1, 1);

    wr(5'h10, 32'hC800); rd(5'h00, s0); wait_lp(5 * SEC_LP); rd(5'h00, s1);
    chk(s1 == s0, "R12 count disabled holds", s1, s0);
    rd(5'h14, v); chk(v[14] == 1, "R12 still running state", v, 32'h4000);

    wr(5'h10, 32'hC808);
    rd(5'h00, s0); wr(5'h08, s0 + 3); wait_lp(6 * SEC_LP);
    rd(5'h14, v); chk(v[3] == 1, "R8 alarm flag", v, 8);
    chk(irq == 0 && wake == 0, "R10 enables off", {30'h0, irq, wake}, 0);
    wr(5'h10, 32'hC898);
    chk(irq == 1 && wake == 1, "R10 enables on", {30'h0, irq, wake}, 3);
    wr(5'h14, 32'h0); wait_lp(2 * SEC_LP);
    rd(5'h14, v); chk(v[3] == 1 && irq == 1, "R9 flag holds", v, 8);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, v); chk(v[3] == 0 && irq == 0, "R9 flag cleared", v, 0);

    for (int i = 0; i < 3; i++) begin
      int off = 2 + int'($urandom % 3);
      rd(5'h00, s0); wr(5'h08, s0 + off);
      wait_lp((off - 1) * SEC_LP - 2);
      rd(5'h14, v); chk(v[3] == 0, "R8 no early flag", v, 0);
      wait_lp(3 * SEC_LP);
      rd(5'h14, v); chk(v[3] == 1 && irq == 1, "R8 random alarm", v, 8);
      wr(5'h14, 32'h8);
    end

    wr_raw(5'h08, 32'hAAAA_0001);
    wr_raw(5'h08, 32'hBBBB_0002);
    settle(); wait_lp(4);
    rd(5'h08, v); chk(v == 32'hAAAA_0001, "R11 write during pending dropped", v, 32'hAAAA_0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule